// File: doc/BRIEF.md
# Channel-Scaled Audio Sample FIFO

This block holds audio samples between a register-mapped data port and a serial framer. The storage is a memory of 24-bit words, and a size code parameter sets how many words it has: 256 shifted left by that code. The number of channels is set at run time. Each channel gets the memory size divided by the channel count rounded up to a power of two, so 3-channel and 5 to 7-channel setups leave part of the memory unused. The fill level is reported in whole frames, where one frame holds one word for each channel.

In playback mode (`cap_mode_i` low), software writes samples through the data register and the framer takes them with a strobe. In capture mode, the framer pushes samples with the strobe and software reads them from the data register. Overrun and underrun are sticky flags that software clears. A control write can flush the FIFO. When a control bit enables it, a service request tells software when the FIFO has room for half its capacity (playback) or holds half its capacity (capture).

Top module: `audio_sample_fifo`

## Requirements
- R1: With size code 0, the frame capacity for channel codes 0..7 (1..8 channels) is 256, 128, 64, 64, 32, 32, 32, 32. The word capacity is the frame capacity times the channel count. `chan_i` is changed only while the FIFO is empty.
- R2: A read of the status register (address 2) returns the stored word count divided by the channel count, rounded down and saturated to 511, in bits 16:8.
- R3: Only bits 23:0 of a data-register write (address 0) are stored. A read of the data register returns the sample in bits 23:0 and zero in bits 31:24.
- R4: A push into a full FIFO is dropped, the stored words are kept, and overrun (status bit 4) is set.
- R5: A pop from an empty FIFO returns zero and sets underrun (status bit 0).
- R6: The flags are sticky. A status write clears each flag whose bit (4 or 0) is written as 0 and leaves a flag whose bit is written as 1.
- R7: A control write (address 1) with bit 0 set empties the FIFO by the next cycle and leaves both flags unchanged. Bit 0 always reads back as 0.
- R8: Control bit 20 is stored and reads back. While it is 0, `svc_req_o` stays low.
- R9: In playback mode with bit 20 set, `svc_req_o` is high exactly when twice the free words is at least the word capacity.
- R10: In capture mode with bit 20 set, `svc_req_o` is high exactly when twice the stored words is at least the word capacity.
- R11: Samples leave in the order they entered. In playback they appear on `fr_data_o` and each strobe pops one. In capture they are read through the data register, and each read pops one.
- R12: After reset the FIFO is empty, both flags are clear, the control register is 0 and `svc_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_mode_i | input | 1 | 1 = capture (framer pushes), 0 = playback (framer pops) |
| chan_i | input | 3 | Channel count minus one |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (a data read pops in capture mode) |
| reg_addr_i | input | 2 | 0 data, 1 control, 2 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| fr_strobe_i | input | 1 | Framer sample strobe |
| fr_data_i | input | 24 | Sample from the framer (capture) |
| fr_data_o | output | 24 | Head sample toward the framer (playback), zero when empty |
| svc_req_o | output | 1 | Half-level service request |

## Verification
The hardest state to reach from the ports is a FIFO filled to exactly its channel-scaled capacity for each channel count. This matters most for the non-power-of-two counts, where the full point lies below the physical memory size. The bench sweeps every channel code. For each one it flushes, pushes one more word than the capacity, and checks that the frame level stops at the capacity and that overrun is set. For three channels it then drains the FIFO and checks that the dropped word never appears.

// File: rtl/audio_sample_fifo_pkg.sv
package audio_sample_fifo_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int REG_W        = 32;
  localparam int SMP_W        = 24;
  localparam int LVL_W        = 9;
  localparam int CTRL_FLUSH_B = 0;
  localparam int CTRL_HALF_B  = 20;
  localparam int STAT_UND_B   = 0;
  localparam int STAT_OVR_B   = 4;
  localparam int STAT_LVL_LSB = 8;
endpackage

// File: rtl/audio_sample_fifo_capacity.sv
module audio_sample_fifo_capacity #(
  parameter int AW = 8
) (
  input  logic [2:0]  chan_code_i,
  output logic [AW:0] cap_words_o
);
  localparam logic [AW:0] MEM_WORDS = (AW+1)'(1) << AW;

  logic [1:0]    shift;
  logic [AW:0]   frames;
  logic [3:0]    chans;
  logic [AW+4:0] prod;

  // halve once per doubling needed to cover the channel count
  always_comb begin
    unique case (chan_code_i)
      3'd0:       shift = 2'd0;
      3'd1:       shift = 2'd1;
      3'd2, 3'd3: shift = 2'd2;
      default:    shift = 2'd3;
    endcase
  end

  assign frames      = MEM_WORDS >> shift;
  assign chans       = {1'b0, chan_code_i} + 4'd1;
  assign prod        = (AW+5)'(frames) * (AW+5)'(chans);
  assign cap_words_o = prod[AW:0];
endmodule

// File: rtl/audio_sample_fifo_store.sv
module audio_sample_fifo_store #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [AW:0]   cap_words_i,
  output logic [DW-1:0] head_o,
  output logic [AW:0]   words_o,
  output logic          ovr_evt_o,
  output logic          und_evt_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   count_q;
  logic          full, empty, push_ok, pop_ok;

  assign full    = count_q >= cap_words_i;
  assign empty   = count_q == '0;
  assign push_ok = push_i & ~full & ~flush_i;
  assign pop_ok  = pop_i & ~empty & ~flush_i;

  assign ovr_evt_o = push_i & full & ~flush_i;
  assign und_evt_o = pop_i & empty & ~flush_i;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q <= count_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  assign head_o  = empty ? '0 : mem_q[rd_ptr_q];
  assign words_o = count_q;
endmodule

// File: rtl/audio_sample_fifo_csr.sv
module audio_sample_fifo_csr
  import audio_sample_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             ovr_evt_i,
  input  logic             und_evt_i,
  output logic             flush_o,
  output logic             half_en_o,
  output logic             ovr_o,
  output logic             und_o
);
  logic ctrl_wr, stat_wr;

  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign stat_wr = reg_we_i && (reg_addr_i == ADDR_STAT);
  assign flush_o = ctrl_wr && reg_wdata_i[CTRL_FLUSH_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_en_o <= 1'b0;
      ovr_o     <= 1'b0;
      und_o     <= 1'b0;
    end else begin
      if (ctrl_wr) half_en_o <= reg_wdata_i[CTRL_HALF_B];
      // a new event wins over a clearing write
      if (ovr_evt_i)                              ovr_o <= 1'b1;
      else if (stat_wr && !reg_wdata_i[STAT_OVR_B]) ovr_o <= 1'b0;
      if (und_evt_i)                              und_o <= 1'b1;
      else if (stat_wr && !reg_wdata_i[STAT_UND_B]) und_o <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import audio_sample_fifo_pkg::*;
#(
  parameter int SIZE_CODE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_mode_i,
  input  logic [2:0]       chan_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             fr_strobe_i,
  input  logic [SMP_W-1:0] fr_data_i,
  output logic [SMP_W-1:0] fr_data_o,
  output logic             svc_req_o
);
  localparam int AW = 8 + SIZE_CODE;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LVL_MAX = CW'((1 << LVL_W) - 1);

  logic             data_sel, push_req, pop_req;
  logic [SMP_W-1:0] push_data, head;
  logic [CW-1:0]    words, cap_words, chan_n, frames;
  logic [LVL_W-1:0] lvl;
  logic             flush, half_en, ovr_flag, und_flag, ovr_evt, und_evt;
  logic [CW:0]      twice_words, twice_free, cap_ext;
  logic             level_ok;

  assign data_sel  = reg_addr_i == ADDR_DATA;
  assign push_req  = cap_mode_i ? fr_strobe_i : (reg_we_i && data_sel);
  assign pop_req   = cap_mode_i ? (reg_re_i && data_sel) : fr_strobe_i;
  assign push_data = cap_mode_i ? fr_data_i : reg_wdata_i[SMP_W-1:0];

  audio_sample_fifo_capacity #(.AW(AW)) u_cap (
    .chan_code_i (chan_i),
    .cap_words_o (cap_words)
  );

  audio_sample_fifo_store #(.AW(AW), .DW(SMP_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .push_i      (push_req),
    .push_data_i (push_data),
    .pop_i       (pop_req),
    .cap_words_i (cap_words),
    .head_o      (head),
    .words_o     (words),
    .ovr_evt_o   (ovr_evt),
    .und_evt_o   (und_evt)
  );

  audio_sample_fifo_csr u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .ovr_evt_i   (ovr_evt),
    .und_evt_i   (und_evt),
    .flush_o     (flush),
    .half_en_o   (half_en),
    .ovr_o       (ovr_flag),
    .und_o       (und_flag)
  );

  // frame level, saturated to the status field width
  assign chan_n = CW'({1'b0, chan_i}) + CW'(1);
  assign frames = words / chan_n;
  assign lvl    = (frames > LVL_MAX) ? LVL_MAX[LVL_W-1:0] : frames[LVL_W-1:0];

  assign twice_words = {words, 1'b0};
  assign twice_free  = {cap_words - words, 1'b0};
  assign cap_ext     = {1'b0, cap_words};
  assign level_ok    = cap_mode_i ? (twice_words >= cap_ext) : (twice_free >= cap_ext);
  assign svc_req_o   = half_en & level_ok;

  assign fr_data_o = cap_mode_i ? '0 : head;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_DATA: if (cap_mode_i) reg_rdata_o[SMP_W-1:0] = head;
      ADDR_CTRL: reg_rdata_o[CTRL_HALF_B] = half_en;
      ADDR_STAT: begin
        reg_rdata_o[STAT_LVL_LSB +: LVL_W] = lvl;
        reg_rdata_o[STAT_OVR_B]            = ovr_flag;
        reg_rdata_o[STAT_UND_B]            = und_flag;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/audio_sample_fifo_chk.sv
module audio_sample_fifo_chk #(
  parameter int CW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cap_mode_i,
  input logic          reg_we_i,
  input logic          reg_re_i,
  input logic [1:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          fr_strobe_i,
  input logic          svc_req_o,
  input logic [CW-1:0] words,
  input logic [CW-1:0] cap_words,
  input logic          ovr_flag,
  input logic          und_flag,
  input logic          half_en
);
  logic flush_wr, stat_wr, push_try, pop_try;
  assign flush_wr = reg_we_i && reg_addr_i == 2'd1 && reg_wdata_i[0];
  assign stat_wr  = reg_we_i && reg_addr_i == 2'd2;
  assign push_try = cap_mode_i ? fr_strobe_i : (reg_we_i && reg_addr_i == 2'd0);
  assign pop_try  = cap_mode_i ? (reg_re_i && reg_addr_i == 2'd0) : fr_strobe_i;

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    words <= cap_words);

  a_r4_overrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_try && words >= cap_words && !flush_wr) |=> ovr_flag);

  a_r5_underrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_try && words == '0 && !flush_wr) |=> und_flag);

  a_r6_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_flag && !(stat_wr && !reg_wdata_i[4])) |=> ovr_flag);

  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_wr |=> words == '0);

  a_r7_flush_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_wr |=> (ovr_flag == $past(ovr_flag) && und_flag == $past(und_flag)));

  a_r8_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_en |-> !svc_req_o);
endmodule

bind audio_sample_fifo audio_sample_fifo_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cap_mode_i  (cap_mode_i),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .fr_strobe_i (fr_strobe_i),
  .svc_req_o   (svc_req_o),
  .words       (words),
  .cap_words   (cap_words),
  .ovr_flag    (ovr_flag),
  .und_flag    (und_flag),
  .half_en     (half_en)
);

// File: tb/audio_sample_fifo_bench.sv
module audio_sample_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_mode = 1'b0;
  logic [2:0]  chan = 3'd0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fr_strobe = 1'b0;
  logic [23:0] fr_din = '0;
  logic [23:0] fr_dout;
  logic        svc_req;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  audio_sample_fifo u_audio_sample_fifo (
    .clk_i(clk), .rst_ni(rst_n), .cap_mode_i(cap_mode), .chan_i(chan),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .fr_strobe_i(fr_strobe), .fr_data_i(fr_din), .fr_data_o(fr_dout),
    .svc_req_o(svc_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic fr_pop(output logic [23:0] d);
    @(negedge clk);
    fr_strobe = 1'b1;
    #1 d = fr_dout;
    @(posedge clk); #1;
    fr_strobe = 1'b0;
  endtask

  task automatic fr_push(input logic [23:0] d);
    @(negedge clk);
    fr_strobe = 1'b1; fr_din = d;
    @(posedge clk); #1;
    fr_strobe = 1'b0;
  endtask

  task automatic req_now(input string req, input logic exp);
    @(negedge clk); #1;
    check(req, {31'd0, svc_req}, {31'd0, exp});
  endtask

  function automatic int cap_frames(input int ch);
    case (ch)
      1: return 256;
      2: return 128;
      3, 4: return 64;
      default: return 32;
    endcase
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    reg_rd(2'd2, d); check("R12 status", d, 32'h0);
    reg_rd(2'd1, d); check("R12 ctrl", d, 32'h0);
    req_now("R12 req", 1'b0);
    check("R12 fr_data", {8'h0, fr_dout}, 32'h0);
  endtask

  task automatic t_order_play;
    logic [31:0] d;
    logic [23:0] s;
    @(negedge clk) chan = 3'd1;
    reg_wr(2'd0, 32'hAB123456);
    reg_wr(2'd0, 32'hFF00ABCD);
    reg_wr(2'd0, 32'h00777777);
    reg_rd(2'd2, d); check("R2 level 3 words / 2 ch", d, 32'h100);
    fr_pop(s); check("R3 R11 pop0", {8'h0, s}, 32'h123456);
    fr_pop(s); check("R3 R11 pop1", {8'h0, s}, 32'h00ABCD);
    fr_pop(s); check("R11 pop2", {8'h0, s}, 32'h777777);
    reg_rd(2'd2, d); check("R11 drained", d, 32'h0);
  endtask

  task automatic t_underrun;
    logic [31:0] d;
    logic [23:0] s;
    @(negedge clk) chan = 3'd0;
    fr_pop(s); check("R5 empty pop data", {8'h0, s}, 32'h0);
    reg_rd(2'd2, d); check("R5 underrun set", d, 32'h1);
    reg_wr(2'd0, 32'h42);
    reg_rd(2'd2, d); check("R6 underrun sticky", d, 32'h101);
    reg_wr(2'd2, 32'h10);
    reg_rd(2'd2, d); check("R6 clear by 0 bit", d, 32'h100);
    reg_wr(2'd1, 32'h1);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    logic [23:0] s;
    fr_pop(s);
    for (int i = 0; i < 4; i++) reg_wr(2'd0, 32'(i + 5));
    reg_rd(2'd2, d); check("R7 pre-flush", d, 32'h401);
    reg_wr(2'd1, 32'h1);
    reg_rd(2'd2, d); check("R7 empty, flag kept", d, 32'h1);
    reg_rd(2'd1, d); check("R7 flush bit reads 0", d, 32'h0);
    reg_wr(2'd2, 32'h0);
    reg_rd(2'd2, d); check("R6 cleared", d, 32'h0);
  endtask

  task automatic t_capacity;
    logic [31:0] d;
    logic [23:0] s;
    int cf, nw, bad;
    for (int c = 1; c <= 8; c++) begin
      reg_wr(2'd1, 32'h1);
      reg_wr(2'd2, 32'h0);
      @(negedge clk) chan = 3'(c - 1);
      cf = cap_frames(c);
      nw = cf * c;
      for (int i = 0; i < nw; i++) reg_wr(2'd0, 32'(i));
      reg_rd(2'd2, d); check($sformatf("R1 full level ch%0d", c), d, 32'(cf << 8));
      reg_wr(2'd0, 32'hBEEF);
      reg_rd(2'd2, d); check($sformatf("R4 overrun ch%0d", c), d, 32'((cf << 8) | 32'h10));
      if (c == 3) begin
        bad = 0;
        for (int i = 0; i < nw; i++) begin
          fr_pop(s);
          if (s !== 24'(i)) bad++;
        end
        check("R4 R11 kept words in order", 32'(bad), 32'h0);
        fr_pop(s); check("R4 dropped word absent", {8'h0, s}, 32'h0);
      end
    end
    reg_wr(2'd1, 32'h1);
    reg_wr(2'd2, 32'h0);
  endtask

  task automatic t_half_play;
    logic [31:0] d;
    logic [23:0] s;
    @(negedge clk) chan = 3'd1;
    req_now("R8 disabled", 1'b0);
    reg_wr(2'd1, 32'h0010_0000);
    reg_rd(2'd1, d); check("R8 readback", d, 32'h0010_0000);
    req_now("R9 empty", 1'b1);
    for (int i = 0; i < 128; i++) reg_wr(2'd0, 32'(i));
    req_now("R9 free 128", 1'b1);
    reg_wr(2'd0, 32'h1);
    req_now("R9 free 127", 1'b0);
    fr_pop(s);
    req_now("R9 free 128 again", 1'b1);
    reg_wr(2'd1, 32'h0010_0001);
  endtask

  task automatic t_half_cap;
    logic [31:0] d;
    @(negedge clk) begin cap_mode = 1'b1; chan = 3'd0; end
    for (int i = 0; i < 127; i++) fr_push(24'(32'h100 + i));
    req_now("R10 127 stored", 1'b0);
    fr_push(24'h17F);
    req_now("R10 128 stored", 1'b1);
    reg_rd(2'd0, d); check("R11 capture first", d, 32'h100);
    reg_rd(2'd0, d); check("R11 capture second", d, 32'h101);
    req_now("R10 126 stored", 1'b0);
    reg_wr(2'd1, 32'h1);
    reg_rd(2'd0, d); check("R5 capture empty read", d, 32'h0);
    reg_rd(2'd2, d); check("R5 capture underrun", d, 32'h1);
    req_now("R8 disabled by write", 1'b0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_order_play();
    t_underrun();
    t_flush();
    t_capacity();
    t_half_play();
    t_half_cap();
    finish_run();
  end
endmodule